// File: doc/BRIEF.md
# Transition-Compressed Capture Recorder

This block records activity on a parallel bus of input channels. It samples the bus on every tick of the sample clock, but it writes a buffer entry only when a channel whose sensitivity bit is set changes value. Each entry holds the whole channel vector and a timestamp. The timestamp counts sample ticks since the block was armed, so long quiet stretches take up no storage. The buffer is circular. Once it is full, new entries overwrite the oldest ones.

Software arms the recorder and then waits for a trigger pulse. After the trigger, the recorder keeps storing entries until it has stored a programmed share of the buffer depth, given as a percentage from 0 to 1000. It then freezes and raises `done_o`. At that point it reports which buffer slot holds the trigger entry and whether any entries were overwritten.

A read port returns the entries in time order: index 0 is always the oldest surviving entry. The base configuration is 64 channels sampled at 100 MHz, which gives a timestamp resolution of 10 ns. Full depth is 128K entries (`ADDR_W` = 17) or 256K entries (`ADDR_W` = 18). The default is kept small for elaboration.

Top module: `trans_capture_rec`

## Requirements
- R1: A one-cycle `arm_i` pulse clears the buffer (`count_o` = 0, `wrapped_o` = 0, `done_o` = 0) and starts recording, with `armed_o` = 1 from the next cycle. The first sample after arming is always stored, and its timestamp is 0.
- R2: While recording, a sample is stored when any channel whose `sens_mask_i` bit is 1 differs from that channel in the most recently stored entry. Changes on channels whose mask bit is 0 store nothing.
- R3: Each entry holds the full sampled vector and the number of sample ticks since arming. The first recording cycle is tick 0, and the count rises by one every recording cycle.
- R4: When the timestamp counter is all ones, the sample is stored whatever the channels do, and the counter then wraps to 0.
- R5: The buffer holds 2^`ADDR_W` entries. `count_o` saturates at that depth. Once an entry has been overwritten, `wrapped_o` is 1.
- R6: The first `trig_i` pulse while recording sets `trig_idx_o` to the physical slot of the most recently stored entry. That includes an entry stored in the same cycle. Later pulses are ignored.
- R7: After the trigger, recording stops at the N-th stored entry, where N is the smallest integer with 100·N ≥ `post_pct_i`·depth. The entry stored in the trigger cycle is not counted. With `post_pct_i` = 0, recording stops in the trigger cycle. `done_o` is 1 from the cycle after the last write.
- R8: While `done_o` is 1, no entry is written. Sample and trigger inputs have no effect until the next arm.
- R9: `rd_idx_i` selects an entry in time order, with 0 the oldest. `rd_data_o` and `rd_ts_o` present that entry one clock later.
- R10: After reset, `armed_o`, `done_o`, `wrapped_o` and `count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Clear and start recording |
| samp_i | input | CH_W | Channel sample vector |
| sens_mask_i | input | CH_W | Per-channel transition sensitivity |
| trig_i | input | 1 | Trigger pulse |
| post_pct_i | input | 11 | Post-trigger share of depth, 0 to 1000 percent |
| armed_o | output | 1 | Recording in progress |
| done_o | output | 1 | Capture complete, buffer frozen |
| wrapped_o | output | 1 | Oldest entries were overwritten |
| count_o | output | ADDR_W+1 | Number of valid entries |
| trig_idx_o | output | ADDR_W | Physical slot of the trigger entry |
| rd_idx_i | input | ADDR_W | Chronological read index |
| rd_data_o | output | CH_W | Channel vector of the selected entry |
| rd_ts_o | output | TS_W | Timestamp of the selected entry |

## Verification
A wrong change baseline or a wrong mask handling shows up in the first cycle after the fault, as a `count_o` step that should not happen or a missing one. The bench compares `count_o` against its model on every recording cycle. A faulty write pointer, wrap flag or oldest-entry offset shows up only at readback, as entries out of order or with shifted timestamps. Every stored entry is read back and compared. Faults in post-trigger accounting move the cycle in which `done_o` rises, and that is checked in the cycle the model predicts.

// File: rtl/trcap_pkg.sv
`timescale 1ns/1ps
package trcap_pkg;
  localparam int PCT_W    = 11;
  localparam int PCT_UNIT = 100;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} rec_st_e;
endpackage

// File: rtl/trcap_chg_det.sv
`timescale 1ns/1ps
module trcap_chg_det #(
  parameter int CH_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] samp_i,
  input  logic [CH_W-1:0] mask_i,
  input  logic            wr_i,
  output logic            chg_o
);
  logic [CH_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else if (wr_i) last_q <= samp_i;
  end

  assign chg_o = |((samp_i ^ last_q) & mask_i);
endmodule

// File: rtl/trcap_ctrl.sv
`timescale 1ns/1ps
module trcap_ctrl
  import trcap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TS_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              chg_i,
  input  logic [PCT_W-1:0]  pct_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [ADDR_W:0]   cnt_o,
  output logic              wrapped_o,
  output logic [ADDR_W-1:0] trig_idx_o,
  output logic              tseen_o,
  output logic              armed_o,
  output logic              done_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam int ACC_W = PCT_W + ADDR_W + 1;

  rec_st_e           st_q;
  logic              first_q, wrap_q, tseen_q;
  logic [TS_W-1:0]   ts_q;
  logic [ADDR_W-1:0] wptr_q, tidx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc_q, acc_nx, target;
  logic              wr;

  assign wr     = (st_q == ST_RUN) && (first_q || chg_i || (&ts_q));
  assign target = ACC_W'({pct_i, {ADDR_W{1'b0}}});
  assign acc_nx = acc_q + ACC_W'(PCT_UNIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      ts_q    <= '0;
      wptr_q  <= '0;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
      tseen_q <= 1'b0;
      tidx_q  <= '0;
      acc_q   <= '0;
    end else if (arm_i) begin
      st_q    <= ST_RUN;
      first_q <= 1'b1;
      ts_q    <= '0;
      wptr_q  <= '0;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
      tseen_q <= 1'b0;
      tidx_q  <= '0;
      acc_q   <= '0;
    end else if (st_q == ST_RUN) begin
      ts_q <= ts_q + TS_W'(1);
      if (wr) begin
        first_q <= 1'b0;
        wptr_q  <= wptr_q + ADDR_W'(1);
        if (cnt_q == CNT_W'(DEPTH)) wrap_q <= 1'b1;
        else cnt_q <= cnt_q + CNT_W'(1);
      end
      if (trig_i && !tseen_q) begin
        tseen_q <= 1'b1;
        tidx_q  <= wr ? wptr_q : wptr_q - ADDR_W'(1);
        acc_q   <= '0;
        if (pct_i == '0) st_q <= ST_DONE;
      end else if (tseen_q && wr) begin
        // post-trigger entries weighed in percent units against pct*depth
        acc_q <= acc_nx;
        if (acc_nx >= target) st_q <= ST_DONE;
      end
    end
  end

  assign wr_o       = wr;
  assign waddr_o    = wptr_q;
  assign ts_o       = ts_q;
  assign cnt_o      = cnt_q;
  assign wrapped_o  = wrap_q;
  assign trig_idx_o = tidx_q;
  assign tseen_o    = tseen_q;
  assign armed_o    = (st_q == ST_RUN);
  assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/trcap_mem.sv
`timescale 1ns/1ps
module trcap_mem #(
  parameter int ADDR_W = 10,
  parameter int DW     = 96
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/trans_capture_rec.sv
`timescale 1ns/1ps
module trans_capture_rec
  import trcap_pkg::*;
#(
  parameter int CH_W   = 64,
  parameter int ADDR_W = 10,
  parameter int TS_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [CH_W-1:0]   samp_i,
  input  logic [CH_W-1:0]   sens_mask_i,
  input  logic              trig_i,
  input  logic [PCT_W-1:0]  post_pct_i,
  output logic              armed_o,
  output logic              done_o,
  output logic              wrapped_o,
  output logic [ADDR_W:0]   count_o,
  output logic [ADDR_W-1:0] trig_idx_o,
  input  logic [ADDR_W-1:0] rd_idx_i,
  output logic [CH_W-1:0]   rd_data_o,
  output logic [TS_W-1:0]   rd_ts_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = CH_W + TS_W;

  logic              wr_en, chg, tseen;
  logic [ADDR_W-1:0] waddr, raddr, oldest;
  logic [TS_W-1:0]   ts;
  logic [DW-1:0]     rdata;

  trcap_chg_det #(.CH_W(CH_W)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (samp_i),
    .mask_i (sens_mask_i),
    .wr_i   (wr_en),
    .chg_o  (chg)
  );

  trcap_ctrl #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .trig_i     (trig_i),
    .chg_i      (chg),
    .pct_i      (post_pct_i),
    .wr_o       (wr_en),
    .waddr_o    (waddr),
    .ts_o       (ts),
    .cnt_o      (count_o),
    .wrapped_o  (wrapped_o),
    .trig_idx_o (trig_idx_o),
    .tseen_o    (tseen),
    .armed_o    (armed_o),
    .done_o     (done_o)
  );

  // once full, the write pointer sits on the oldest entry
  assign oldest = (count_o == (ADDR_W+1)'(DEPTH)) ? waddr : '0;
  assign raddr  = oldest + rd_idx_i;

  trcap_mem #(.ADDR_W(ADDR_W), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .wr_i    (wr_en),
    .waddr_i (waddr),
    .wdata_i ({samp_i, ts}),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign rd_data_o = rdata[DW-1:TS_W];
  assign rd_ts_o   = rdata[TS_W-1:0];
endmodule

// File: rtl/trans_capture_rec_chk.sv
`timescale 1ns/1ps
module trans_capture_rec_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              trig_i,
  input logic [10:0]       post_pct_i,
  input logic              wr_en,
  input logic              tseen,
  input logic              armed_o,
  input logic              done_o,
  input logic              wrapped_o,
  input logic [ADDR_W:0]   count_o
);
  localparam int DEPTH = 1 << ADDR_W;

  a_r1_first_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> wr_en);

  a_r5_wrap_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_o |-> (count_o == (ADDR_W+1)'(DEPTH)));

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= (ADDR_W+1)'(DEPTH));

  a_r7_zero_pct_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !arm_i && trig_i && !tseen && post_pct_i == '0) |=> done_o);

  a_r8_no_write_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en);

  a_r8_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> $stable(count_o));
endmodule

bind trans_capture_rec trans_capture_rec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .trig_i     (trig_i),
  .post_pct_i (post_pct_i),
  .wr_en      (wr_en),
  .tseen      (tseen),
  .armed_o    (armed_o),
  .done_o     (done_o),
  .wrapped_o  (wrapped_o),
  .count_o    (count_o)
);

// File: tb/trans_capture_rec_tb_top.sv
`timescale 1ns/1ps
module trans_capture_rec_tb_top;
  localparam int CH_W   = 8;
  localparam int ADDR_W = 4;
  localparam int TS_W   = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              arm_i = 1'b0;
  logic [CH_W-1:0]   samp_i = '0;
  logic [CH_W-1:0]   sens_mask_i = '0;
  logic              trig_i = 1'b0;
  logic [10:0]       post_pct_i = '0;
  logic              armed_o, done_o, wrapped_o;
  logic [ADDR_W:0]   count_o;
  logic [ADDR_W-1:0] trig_idx_o;
  logic [ADDR_W-1:0] rd_idx_i = '0;
  logic [CH_W-1:0]   rd_data_o;
  logic [TS_W-1:0]   rd_ts_o;

  always #2.5 clk = ~clk;

  trans_capture_rec #(.CH_W(CH_W), .ADDR_W(ADDR_W), .TS_W(TS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .samp_i(samp_i),
    .sens_mask_i(sens_mask_i), .trig_i(trig_i), .post_pct_i(post_pct_i),
    .armed_o(armed_o), .done_o(done_o), .wrapped_o(wrapped_o),
    .count_o(count_o), .trig_idx_o(trig_idx_o), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .rd_ts_o(rd_ts_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // scoreboard queues filled by the driver, drained by the readback monitor
  logic [CH_W-1:0] exp_ch[$];
  logic [TS_W-1:0] exp_ts[$];
  logic [CH_W-1:0] m_last, m_mask;
  logic [TS_W-1:0] m_ts;
  bit m_run, m_first, m_tseen, m_wrap;
  int m_total, m_tidx, m_acc, m_pct;
  logic [CH_W-1:0] lfsr = 8'h5b;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_arm(input logic [CH_W-1:0] mask, input int pct);
    exp_ch.delete(); exp_ts.delete();
    m_run = 1; m_first = 1; m_tseen = 0; m_wrap = 0;
    m_ts = '0; m_total = 0; m_acc = 0; m_pct = pct; m_mask = mask; m_last = '0;
  endtask

  task automatic drive_step(input logic [CH_W-1:0] s, input logic t);
    bit wr;
    arm_i = 1'b0; samp_i = s; trig_i = t;
    if (m_run) begin
      wr = m_first || (((s ^ m_last) & m_mask) != '0) || (&m_ts);
      if (wr) begin
        exp_ch.push_back(s); exp_ts.push_back(m_ts);
        if (exp_ch.size() > DEPTH) begin
          void'(exp_ch.pop_front()); void'(exp_ts.pop_front()); m_wrap = 1;
        end
        m_last = s; m_first = 0; m_total++;
      end
      if (t && !m_tseen) begin
        m_tseen = 1; m_tidx = (m_total - 1) % DEPTH; m_acc = 0;
        if (m_pct == 0) m_run = 0;
      end else if (m_tseen && wr) begin
        m_acc += 100;
        if (m_acc >= m_pct * DEPTH) m_run = 0;
      end
      m_ts = m_ts + 1'b1;
    end
  endtask

  function automatic logic [CH_W-1:0] next_pat(input int mode);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (mode)
      1: return 8'h5a;
      2: return {lfsr[7:4], 4'h5};
      default: return lfsr;
    endcase
  endfunction

  task automatic readback();
    int n = exp_ch.size();
    check(int'(count_o) == n, "R5 count", count_o, n);
    for (int i = 0; i < n; i++) begin
      logic [CH_W-1:0] ec; logic [TS_W-1:0] et;
      ec = exp_ch.pop_front(); et = exp_ts.pop_front();
      rd_idx_i = ADDR_W'(i);
      @(negedge clk);
      check(rd_data_o == ec, "R9 data", rd_data_o, ec);
      check(rd_ts_o == et, "R3 timestamp", rd_ts_o, et);
    end
  endtask

  task automatic run_capture(input logic [CH_W-1:0] mask, input int pct,
                             input int trig_at, input int mode, input int max_cyc);
    @(negedge clk);
    arm_i = 1'b1; sens_mask_i = mask; post_pct_i = 11'(pct); trig_i = 1'b0;
    model_arm(mask, pct);
    @(negedge clk);
    check(armed_o && !done_o && !wrapped_o && count_o == '0, "R1 armed clear",
          {armed_o, done_o, wrapped_o, count_o}, {1'b1, 2'b0, {(ADDR_W+1){1'b0}}});
    for (int c = 0; c < max_cyc && m_run; c++) begin
      if (c > 0) check(int'(count_o) == exp_ch.size(), "R2 entry count", count_o, exp_ch.size());
      if (mode == 2 && c == 100) check(count_o == 1, "R2 masked channels ignored", count_o, 1);
      drive_step(next_pat(mode), c == trig_at || c == trig_at + 3);
      @(negedge clk);
    end
    check(done_o == !m_run, "R7 done timing", done_o, !m_run);
    check(trig_idx_o == ADDR_W'(m_tidx), "R6 trigger slot", trig_idx_o, m_tidx);
    check(wrapped_o == m_wrap, "R5 wrapped", wrapped_o, m_wrap);
    // inputs toggle after completion and must leave the buffer alone
    for (int c = 0; c < 20; c++) begin
      drive_step(next_pat(0), c[0]);
      @(negedge clk);
    end
    check(done_o && int'(count_o) == exp_ch.size(), "R8 frozen", count_o, exp_ch.size());
    readback();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!armed_o && !done_o && !wrapped_o && count_o == '0, "R10 reset state",
          {armed_o, done_o, wrapped_o, count_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!armed_o && count_o == '0, "R10 idle after reset", count_o, 0);
    run_capture(8'h0f, 50, 10, 0, 400);    // R2 R6 R7 partial fill
    run_capture(8'hff, 1000, 5, 0, 2000);  // R5 wrap, R7 max share
    run_capture(8'hff, 0, 7, 0, 400);      // R7 zero share
    run_capture(8'h0f, 25, 3, 2, 3000);    // R2 masked, R4 forced entries
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule